// File: doc/BRIEF.md
# Serial Speech ROM Reader

This block feeds a speech synthesis processor from a byte-wide speech memory, one bit at a time. The processor asks for each bit with a request pulse. The block keeps a 16-bit byte address and a 3-bit bit index. The bit index chooses one bit of the memory byte at the current address, and the chosen bit is handed out on a single serial line. Bits leave least significant first. After the eighth bit of a byte, the address moves on to the next byte.

Before an utterance starts, a host sets the start address as two bytes. Each byte has its own active-low strobe. The low byte goes in first, and loading it also restarts the bit index at bit 0. The host then loads the high byte. Loading the high byte leaves the low byte and the bit index as they were.

The request pulse arrives from another timing domain. Inside the block it is synchronised and split into a rising event and a falling event. On the rising event the selected bit is captured into an output register. On the falling event the bit index and the address advance. Because the captured bit sits in a register, it does not change while the index and the address move underneath it.

The serial output is paced only by request pulses and has no handshake. The memory address is a plain output, and the byte it selects must be present on the memory data input combinationally. The memory itself is outside the block.

Top module: `speech_rom_serializer`

## Requirements
- R1: While `load_lo_n` is low at a rising clock edge, `mem_addr[7:0]` takes the value of `host_data` from the next cycle on.
- R2: While `load_hi_n` is low at a rising clock edge, `mem_addr[15:8]` takes the value of `host_data`. `mem_addr[7:0]` and the bit index are left unchanged.
- R3: A low-byte load resets the bit index to 0. The next bit delivered is therefore bit 0 of the byte at the new address.
- R4: Bits of a byte are delivered in the order 0, 1, 2 … 7, that is, least significant bit first. The bit index moves up by one on each falling edge of the request and counts modulo 8.
- R5: When the bit index wraps from 7 to 0, `mem_addr` increases by one. The address rolls over from 0xFFFF to 0x0000. At any other time it changes only through a load.
- R6: `ser_bit` changes only on the rising event of a request. It keeps its value through the falling event, when the index and the address advance.
- R7: After reset, `mem_addr` is 0x0000, the bit index is 0 and `ser_bit` is 0.
- R8: The request passes through a two-flop synchroniser. `ser_bit` shows the new bit after the third rising clock edge that follows the request going high, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 8 | Address byte from the host |
| load_lo_n | input | 1 | Active-low strobe that loads the low address byte and clears the bit index |
| load_hi_n | input | 1 | Active-low strobe that loads the high address byte |
| req_pulse | input | 1 | Bit request from the synthesis processor (asynchronous) |
| mem_addr | output | 16 | Byte address to the speech memory |
| mem_data | input | 8 | Byte read from the speech memory at `mem_addr` |
| ser_bit | output | 1 | Registered serial data bit |

## Verification
The main check is long runs of requests from random start addresses, taken against a memory whose contents are a function of the address. These runs separate a correct bit order from a reversed or shifted one, and show whether the address steps at the right byte boundary. Several directed cases cover the rest:
- A low-byte reload partway through a byte shows that the bit index restarts.
- A load of the high byte alone shows that the low byte and the index stay put.
- A start address of 0xFFFF exercises the rollover.
- Sampling `ser_bit` both before and after the third clock edge following each request separates a correct synchroniser depth from one that is too shallow or too deep.
- Sampling `ser_bit` again after the falling event shows that the output register holds the captured bit.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 2;
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int SEL_W      = $clog2(BYTE_W);
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/srr_pulse_sync.sv
module srr_pulse_sync #(
  parameter int STAGES = srr_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], req_i};
  end

  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];

  assert_edges_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  assert_rise_then_no_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/srr_bit_counter.sv
module srr_bit_counter #(
  parameter int CNT_W = srr_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i && !clear_i && (cnt_q == CNT_MAX);

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt_o == '0);
  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clear_i) |=> cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(cnt_o));
endmodule

// File: rtl/srr_addr_counter.sv
module srr_addr_counter #(
  parameter int LANES  = srr_pkg::ADDR_BYTES,
  parameter int LANE_W = srr_pkg::BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        load_i,
  input  logic [LANE_W-1:0]       data_i,
  input  logic                    inc_i,
  output logic [LANES*LANE_W-1:0] addr_o
);
  localparam int AW = LANES * LANE_W;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_inc;

  assign addr_inc = addr_q + AW'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        addr_q[g*LANE_W +: LANE_W] <= '0;
      else if (load_i[g])
        addr_q[g*LANE_W +: LANE_W] <= data_i;
      else if (inc_i)
        addr_q[g*LANE_W +: LANE_W] <= addr_inc[g*LANE_W +: LANE_W];
    end
  end

  assign addr_o = addr_q;

  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && load_i == '0) |=> addr_o == AW'($past(addr_o) + AW'(1)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && load_i == '0) |=> $stable(addr_o));
endmodule

// File: rtl/srr_bit_select.sv
module srr_bit_select #(
  parameter int BYTE_W = srr_pkg::BYTE_W,
  parameter int SEL_W  = srr_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              bit_o
);
  logic picked;
  logic bit_q;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (sel_i == SEL_W'(i)) picked = byte_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bit_q <= 1'b0;
    else if (capture_i) bit_q <= picked;
  end

  assign bit_o = bit_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(bit_o));
endmodule

// File: rtl/speech_rom_serializer.sv
module speech_rom_serializer
  import srr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] host_data,
  input  logic              load_lo_n,
  input  logic              load_hi_n,
  input  logic              req_pulse,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              ser_bit
);
  logic             req_rise, req_fall;
  logic [SEL_W-1:0] bit_idx;
  logic             idx_wrap;
  logic [ADDR_BYTES-1:0] lane_load;

  assign lane_load = {~load_hi_n, ~load_lo_n};

  srr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .req_i(req_pulse),
    .rise_o(req_rise), .fall_o(req_fall)
  );

  srr_bit_counter #(.CNT_W(SEL_W)) u_bitcnt (
    .clk(clk), .rst_n(rst_n), .clear_i(~load_lo_n), .step_i(req_fall),
    .cnt_o(bit_idx), .wrap_o(idx_wrap)
  );

  srr_addr_counter #(.LANES(ADDR_BYTES), .LANE_W(BYTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(lane_load), .data_i(host_data),
    .inc_i(idx_wrap), .addr_o(mem_addr)
  );

  srr_bit_select #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .capture_i(req_rise), .sel_i(bit_idx),
    .byte_i(mem_data), .bit_o(ser_bit)
  );

  assert_load_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lo_n |=> mem_addr[BYTE_W-1:0] == $past(host_data));
  assert_load_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hi_n |=> mem_addr[ADDR_W-1:BYTE_W] == $past(host_data));
  assert_hi_keeps_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hi_n && load_lo_n && !req_fall) |=> $stable(mem_addr[BYTE_W-1:0]));
  assert_lo_clears_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lo_n |=> bit_idx == '0);
  assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fall && bit_idx == '1 && load_lo_n && load_hi_n)
      |=> mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1)));
  assert_fall_keeps_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fall |=> $stable(ser_bit));
  assert_capture_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> ser_bit == $past(mem_data[bit_idx]));
endmodule

// File: tb/tb_speech_rom_serializer.sv
module tb_speech_rom_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = 8'h00;
  logic        load_lo_n = 1'b1;
  logic        load_hi_n = 1'b1;
  logic        req_pulse = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        ser_bit;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_addr = 16'h0000;
  int          exp_idx  = 0;
  logic        exp_bit  = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] model_byte(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  assign mem_data = model_byte(mem_addr);

  speech_rom_serializer dut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data),
    .load_lo_n(load_lo_n), .load_hi_n(load_hi_n), .req_pulse(req_pulse),
    .mem_addr(mem_addr), .mem_data(mem_data), .ser_bit(ser_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_lo(input logic [7:0] b);
    host_data = b; load_lo_n = 1'b0;
    @(posedge clk); @(negedge clk);
    load_lo_n = 1'b1;
    exp_addr[7:0] = b; exp_idx = 0;
    chk("R1 low byte", {16'h0, mem_addr[7:0]}, {24'h0, b});
  endtask

  task automatic load_hi(input logic [7:0] b);
    logic [7:0] lo_before;
    lo_before = mem_addr[7:0];
    host_data = b; load_hi_n = 1'b0;
    @(posedge clk); @(negedge clk);
    load_hi_n = 1'b1;
    exp_addr[15:8] = b;
    chk("R2 high byte", {16'h0, mem_addr[15:8]}, {24'h0, b});
    chk("R2 low byte kept", {24'h0, mem_addr[7:0]}, {24'h0, lo_before});
  endtask

  task automatic request();
    logic old_bit;
    logic [7:0] byte_v;
    old_bit = ser_bit;
    req_pulse = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 not yet after two edges", {31'h0, ser_bit}, {31'h0, old_bit});
    @(posedge clk); @(negedge clk);
    byte_v  = model_byte(exp_addr);
    exp_bit = byte_v[exp_idx];
    chk("R4 bit value", {31'h0, ser_bit}, {31'h0, exp_bit});
    req_pulse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_idx++;
    if (exp_idx == 8) begin
      exp_idx  = 0;
      exp_addr = exp_addr + 16'd1;
    end
    chk("R6 bit held across advance", {31'h0, ser_bit}, {31'h0, exp_bit});
    chk("R5 address", {16'h0, mem_addr}, {16'h0, exp_addr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    chk("R7 address after reset", {16'h0, mem_addr}, 32'h0);
    chk("R7 bit after reset", {31'h0, ser_bit}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: bit index 0 after reset -> first bit is bit 0 of byte 0
    request();

    // directed: start at 0x1234, run across byte boundaries
    load_lo(8'h34);
    load_hi(8'h12);
    for (int i = 0; i < 20; i++) request();

    // R3: reload low byte in the middle of a byte
    for (int i = 0; i < 3; i++) request();
    load_lo(8'h80);
    chk("R3 address after reload", {16'h0, mem_addr}, {16'h0, exp_addr});
    for (int i = 0; i < 9; i++) request();

    // R2: high byte alone keeps low byte and bit index
    for (int i = 0; i < 2; i++) request();
    load_hi(8'hC3);
    for (int i = 0; i < 7; i++) request();

    // R5: rollover 0xFFFF -> 0x0000
    load_lo(8'hFF);
    load_hi(8'hFF);
    for (int i = 0; i < 8; i++) request();
    chk("R5 rollover to zero", {16'h0, mem_addr}, 32'h0);
    for (int i = 0; i < 4; i++) request();

    // random words
    for (int w = 0; w < 15; w++) begin
      int n;
      load_lo(8'($urandom));
      load_hi(8'($urandom));
      n = 1 + int'($urandom % 40);
      for (int i = 0; i < n; i++) request();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule